// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block lets a host read and write a byte-wide configuration register file over a three-wire serial link. The link has an active-low chip select, a serial clock and one data line that carries data both ways. All three bus inputs are brought into the fast system clock through two-flop synchronizers. Clock edges are found from the synchronized samples, so the serial clock never clocks any flop directly.

A frame opens with a 16-bit instruction header. The header holds a direction flag, a two-bit length code and a 13-bit address. Data bytes follow the header. On a write, the slave shifts in each byte and stores it at the current address. On a read, it drives bits from the register file onto the data line. The address steps by one after every byte. A mode bit in register 0x00 flips the bit order of the whole frame, header included. The new order takes effect only at the next frame.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset every register reads 0x00 and the data output enable is low.
- R2: In MSB-first order the header bits arrive as direction (1 = read), length bit 1, length bit 0, then address bits 12 down to 0. Data bytes arrive bit 7 first.
- R3: Length code 00, 01 and 10 moves 1, 2 and 3 bytes. The address starts at the header address and rises by one per byte. Bits clocked after the last byte are ignored.
- R4: Length code 11 streams bytes at rising addresses until chip select goes high.
- R5: On a read, each data bit changes only after a falling serial clock edge, so the host can sample it on the next rising edge. The output enable is high only in the data phase of a read.
- R6: When bit 6 of register 0x00 is 1, the frame is LSB-first. The header arrives as address bit 0 up to 12, then length bit 0, length bit 1 and the direction flag, and data bytes arrive bit 0 first.
- R7: A change of the order bit takes effect only in the next frame after chip select goes high. The rest of the current frame keeps its order.
- R8: Writes to addresses 0x100 and above change no register, and reads there return 0x00. The bits of register 0x00 other than bit 6 always read 0.
- R9: Chip select going high at any point ends the frame. The output enable drops, a partial byte is discarded, and the next frame decodes a fresh header.
- R10: Transfers are correct with the serial clock at the system clock divided by 16 for writes and by 66 for reads. No lower limit or timeout applies to the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdio_in | input | 1 | Data line as seen at the pad input |
| spi_sdio_out | output | 1 | Read data toward the pad |
| spi_sdio_oe | output | 1 | Pad output enable for the data line |

## Verification
The hardest case to reach is a bit-order change in the middle of a frame. The stimulus streams a write that starts at register 0x00: the first byte sets the order bit and the second byte goes to register 0x01. That second byte uses a value whose bit reversal is different from itself, so a read of register 0x01 in the next frame shows whether the order switched too early. Aborts are forced by raising chip select part-way through a data byte, both on a write and on a read. The rate limits are reached by running write frames at the divide-by-16 rate and read frames at the divide-by-66 rate, plus a much slower pair of frames.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int HDR_BITS = 16;
    localparam int ADR_W    = 13;
    localparam int BYTE_W   = 8;

    typedef struct packed {
        logic             rd;
        logic [1:0]       len;
        logic [ADR_W-1:0] addr;
    } hdr_t;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic act;
        logic rise;
        logic fall;
        logic din;
    } spi_ev_t;

    function automatic logic [HDR_BITS-1:0] hdr_shift(logic [HDR_BITS-1:0] cur,
                                                      logic b, logic lsb);
        return lsb ? {b, cur[HDR_BITS-1:1]} : {cur[HDR_BITS-2:0], b};
    endfunction

    function automatic logic [BYTE_W-1:0] byte_shift_in(logic [BYTE_W-1:0] cur,
                                                        logic b, logic lsb);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic byte_head(logic [BYTE_W-1:0] cur, logic lsb);
        return lsb ? cur[0] : cur[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] byte_shift_out(logic [BYTE_W-1:0] cur,
                                                         logic lsb);
        return lsb ? {1'b0, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= RST_VAL;
            end else begin
                if (s == 0) stg[s] <= d;
                else        stg[s] <= stg[(s > 0) ? s-1 : 0];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_spi_front.sv
module cfg_spi_front
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    csn,
    input  logic    sclk,
    input  logic    sdi,
    output spi_ev_t ev
);
    logic [2:0] s_q;
    logic       sclk_d;

    cfg_spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({csn, sclk, sdi}),
        .q  (s_q)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= s_q[1];
    end

    always_comb begin
        ev.act  = ~s_q[2];
        ev.rise = ~s_q[2] &  s_q[1] & ~sclk_d;
        ev.fall = ~s_q[2] & ~s_q[1] &  sclk_d;
        ev.din  = s_q[0];
    end
endmodule

// File: rtl/cfg_spi_engine.sv
module cfg_spi_engine
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_ev_t           ev,
    input  logic              cfg_lsb,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADR_W-1:0]  rd_addr,
    output logic              wr_en,
    output logic [ADR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [3:0] HDR_LAST  = 4'(HDR_BITS - 1);
    localparam logic [3:0] BYTE_LAST = 4'(BYTE_W - 1);

    phase_e              phase_q,  phase_n;
    logic [HDR_BITS-1:0] hsh_q,    hsh_n;
    logic [3:0]          cnt_q,    cnt_n;
    hdr_t                hdr_q,    hdr_n;
    logic [ADR_W-1:0]    addr_q,   addr_n;
    logic [1:0]          left_q,   left_n;
    logic                strm_q,   strm_n;
    logic [BYTE_W-1:0]   dsh_q,    dsh_n;
    logic [BYTE_W-1:0]   rsh_q,    rsh_n;
    logic                lsb_q,    lsb_n;
    logic                sdo_q,    sdo_n;
    logic                oe_q;

    logic [HDR_BITS-1:0] hsh_nx;
    hdr_t                hdr_in;
    logic                hdr_done;
    logic                byte_done;
    logic [ADR_W-1:0]    addr_inc;

    always_comb begin
        hsh_nx    = hdr_shift(hsh_q, ev.din, lsb_q);
        hdr_in    = hdr_t'(hsh_nx);
        hdr_done  = ev.rise && (phase_q == PH_HDR)  && (cnt_q == HDR_LAST);
        byte_done = ev.rise && (phase_q == PH_DATA) && (cnt_q == BYTE_LAST);
        addr_inc  = addr_q + ADR_W'(1);
        rd_addr   = (phase_q == PH_HDR) ? hdr_in.addr : addr_inc;
        wr_en     = byte_done && !hdr_q.rd;
        wr_addr   = addr_q;
        wr_data   = byte_shift_in(dsh_q, ev.din, lsb_q);
    end

    always_comb begin
        phase_n = phase_q;
        hsh_n   = hsh_q;
        cnt_n   = cnt_q;
        hdr_n   = hdr_q;
        addr_n  = addr_q;
        left_n  = left_q;
        strm_n  = strm_q;
        dsh_n   = dsh_q;
        rsh_n   = rsh_q;
        lsb_n   = lsb_q;
        sdo_n   = sdo_q;
        if (!ev.act) begin
            phase_n = PH_HDR;
            hsh_n   = '0;
            cnt_n   = '0;
            lsb_n   = cfg_lsb;
        end else begin
            unique case (phase_q)
                PH_HDR: begin
                    if (ev.rise) begin
                        hsh_n = hsh_nx;
                        cnt_n = cnt_q + 4'd1;
                        if (hdr_done) begin
                            phase_n = PH_DATA;
                            hdr_n   = hdr_in;
                            addr_n  = hdr_in.addr;
                            left_n  = hdr_in.len;
                            strm_n  = (hdr_in.len == 2'b11);
                            cnt_n   = '0;
                            rsh_n   = rd_byte;
                        end
                    end
                end
                PH_DATA: begin
                    if (ev.rise) begin
                        dsh_n = wr_data;
                        cnt_n = cnt_q + 4'd1;
                        if (byte_done) begin
                            cnt_n  = '0;
                            addr_n = addr_inc;
                            rsh_n  = rd_byte;
                            if (!strm_q) begin
                                if (left_q == 2'd0) phase_n = PH_DONE;
                                else                left_n  = left_q - 2'd1;
                            end
                        end
                    end else if (ev.fall && hdr_q.rd) begin
                        sdo_n = byte_head(rsh_q, lsb_q);
                        rsh_n = byte_shift_out(rsh_q, lsb_q);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HDR;
            hsh_q   <= '0;
            cnt_q   <= '0;
            hdr_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            strm_q  <= 1'b0;
            dsh_q   <= '0;
            rsh_q   <= '0;
            lsb_q   <= 1'b0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            phase_q <= phase_n;
            hsh_q   <= hsh_n;
            cnt_q   <= cnt_n;
            hdr_q   <= hdr_n;
            addr_q  <= addr_n;
            left_q  <= left_n;
            strm_q  <= strm_n;
            dsh_q   <= dsh_n;
            rsh_q   <= rsh_n;
            lsb_q   <= lsb_n;
            sdo_q   <= sdo_n;
            oe_q    <= ev.act && (phase_n == PH_DATA) && hdr_n.rd;
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;

    // R5: the read bit moves only after a detected falling clock edge
    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !ev.fall |=> $stable(sdo));

    // R9: losing chip select releases the data line on the next cycle
    p_oe_release_r9: assert property (@(posedge clk) disable iff (rst)
        !ev.act |=> !sdo_oe);

    // R7: the frame bit order cannot change while chip select is held
    p_order_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        ev.act |=> $stable(lsb_q));

    // R2: the sixteenth header bit moves the frame into its data phase
    p_hdr_to_data_r2: assert property (@(posedge clk) disable iff (rst)
        hdr_done |=> (phase_q == PH_DATA));

    // R3: no write strobe after the byte budget of a frame is spent
    p_no_write_after_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |-> !wr_en);
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
    import cfg_spi_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int MODE_ADDR = 0,
    parameter int MODE_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cfg_lsb
);
    localparam int                IDX_W     = $clog2(DEPTH);
    localparam logic [ADR_W:0]    LIMIT     = (ADR_W+1)'(DEPTH);
    localparam logic [BYTE_W-1:0] MODE_MASK = BYTE_W'(1) << MODE_BIT;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              wr_ok;
    logic              rd_ok;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        wr_ok  = ({1'b0, wr_addr} < LIMIT);
        rd_ok  = ({1'b0, rd_addr} < LIMIT);
        wr_idx = wr_addr[IDX_W-1:0];
        rd_idx = rd_addr[IDX_W-1:0];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] KEEP = (i == MODE_ADDR) ? MODE_MASK : '1;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && wr_ok && (wr_idx == IDX_W'(i))) begin
                mem[i] <= wr_data & KEEP;
            end
        end
    end

    assign rd_byte = rd_ok ? mem[rd_idx] : '0;
    assign cfg_lsb = mem[MODE_ADDR][MODE_BIT];

    // R8: reserved bits of the order register never become set
    p_reserved_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (mem[MODE_ADDR] & ~MODE_MASK) == '0);
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_DEPTH   = 256,
    parameter int MODE_ADDR   = 0,
    parameter int MODE_BIT    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_csn,
    input  logic spi_sclk,
    input  logic spi_sdio_in,
    output logic spi_sdio_out,
    output logic spi_sdio_oe
);
    spi_ev_t           ev;
    logic              cfg_lsb;
    logic [BYTE_W-1:0] rd_byte;
    logic [ADR_W-1:0]  rd_addr;
    logic              wr_en;
    logic [ADR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;

    cfg_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk (clk),
        .rst (rst),
        .csn (spi_csn),
        .sclk(spi_sclk),
        .sdi (spi_sdio_in),
        .ev  (ev)
    );

    cfg_spi_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .cfg_lsb(cfg_lsb),
        .rd_byte(rd_byte),
        .rd_addr(rd_addr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .sdo    (spi_sdio_out),
        .sdo_oe (spi_sdio_oe)
    );

    cfg_spi_regfile #(
        .DEPTH    (REG_DEPTH),
        .MODE_ADDR(MODE_ADDR),
        .MODE_BIT (MODE_BIT)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_byte(rd_byte),
        .cfg_lsb(cfg_lsb)
    );
endmodule

// File: tb/cfg_spi_slave_tb.sv
module cfg_spi_slave_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [7:0] tx [8];
    logic [7:0] rx [8];
    logic oe_hi_seen;
    logic oe_lo_seen;

    localparam int WR_HALF = 8;
    localparam int RD_HALF = 33;
    localparam int WATCHDOG = 190000;

    always #5 clk = ~clk;

    cfg_spi_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .spi_csn     (csn),
        .spi_sclk    (sclk),
        .spi_sdio_in (sdi),
        .spi_sdio_out(sdo),
        .spi_sdio_oe (oe)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not end, actual=%0d expected<%0d cycles",
                     cyc, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame; nbits data bits are clocked, then chip select goes high.
    task automatic xfer(input bit lsb, input bit rd, input logic [1:0] w,
                        input logic [12:0] a, input int nbits, input int half);
        logic [15:0] hv;
        hv = {rd, w, a};
        oe_hi_seen = 1'b0;
        oe_lo_seen = 1'b0;
        foreach (rx[k]) rx[k] = 8'h00;
        @(negedge clk);
        csn = 1'b0;
        wait_clk(half);
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0;
            sdi  = lsb ? hv[i] : hv[15-i];
            wait_clk(half);
            sclk = 1'b1;
            wait_clk(half);
        end
        for (int j = 0; j < nbits; j++) begin
            int bi;
            int ki;
            bi = j / 8;
            ki = lsb ? (j % 8) : (7 - (j % 8));
            sclk = 1'b0;
            sdi  = tx[bi][ki];
            wait_clk(half);
            if (oe) oe_hi_seen = 1'b1;
            else    oe_lo_seen = 1'b1;
            rx[bi][ki] = sdo;
            sclk = 1'b1;
            wait_clk(half);
        end
        sclk = 1'b0;
        wait_clk(half);
        csn = 1'b1;
        wait_clk(12);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", oe, 1'b0);
        xfer(0, 1, 2'b00, 13'h005, 8, RD_HALF);
        chk("R1 reg 0x05 reset value", rx[0], 8'h00);
        chk("R1 reg 0x00 reset value via order", oe, 1'b0);
    endtask

    task automatic t_msb_rw();
        tx[0] = 8'hA1; tx[1] = 8'hB2; tx[2] = 8'hC3;
        xfer(0, 0, 2'b10, 13'h020, 24, WR_HALF);
        chk("R5 oe stays low on write", oe_hi_seen, 1'b0);
        xfer(0, 1, 2'b10, 13'h020, 24, RD_HALF);
        chk("R2 read byte 0x20", rx[0], 8'hA1);
        chk("R3 read byte 0x21", rx[1], 8'hB2);
        chk("R10 read byte 0x22 at /66", rx[2], 8'hC3);
        chk("R5 oe high through read data", oe_lo_seen, 1'b0);
        chk("R5 oe released after frame", oe, 1'b0);
    endtask

    task automatic t_len_limit();
        tx[0] = 8'h11; tx[1] = 8'h22;
        xfer(0, 0, 2'b00, 13'h030, 16, WR_HALF);
        xfer(0, 1, 2'b01, 13'h030, 16, RD_HALF);
        chk("R3 single byte stored", rx[0], 8'h11);
        chk("R3 byte past length ignored", rx[1], 8'h00);
        tx[0] = 8'h33; tx[1] = 8'h44;
        xfer(0, 0, 2'b01, 13'h034, 16, WR_HALF);
        xfer(0, 1, 2'b10, 13'h034, 24, RD_HALF);
        chk("R3 two byte write first", rx[0], 8'h33);
        chk("R3 two byte write second", rx[1], 8'h44);
        chk("R3 third address untouched", rx[2], 8'h00);
    endtask

    task automatic t_stream();
        for (int k = 0; k < 5; k++) tx[k] = 8'(8'h51 + 8'(k * 17));
        xfer(0, 0, 2'b11, 13'h040, 40, WR_HALF);
        xfer(0, 1, 2'b11, 13'h040, 40, RD_HALF);
        for (int k = 0; k < 5; k++)
            chk($sformatf("R4 streamed byte %0d", k), rx[k], 8'(8'h51 + 8'(k * 17)));
    endtask

    task automatic t_high();
        tx[0] = 8'h5A; tx[1] = 8'h6B; tx[2] = 8'h7C;
        xfer(0, 0, 2'b11, 13'h0FE, 24, WR_HALF);
        xfer(0, 1, 2'b01, 13'h0FE, 16, RD_HALF);
        chk("R8 byte at 0xFE", rx[0], 8'h5A);
        chk("R8 byte at 0xFF", rx[1], 8'h6B);
        xfer(0, 1, 2'b00, 13'h100, 8, RD_HALF);
        chk("R8 read above 0xFF is zero", rx[0], 8'h00);
        tx[0] = 8'hE7;
        xfer(0, 0, 2'b00, 13'h1000, 8, WR_HALF);
        xfer(0, 1, 2'b01, 13'h000, 16, RD_HALF);
        chk("R8 high write leaves 0x00", rx[0], 8'h00);
        chk("R8 high write leaves 0x01", rx[1], 8'h00);
    endtask

    task automatic t_abort();
        tx[0] = 8'hFF;
        xfer(0, 0, 2'b00, 13'h050, 4, WR_HALF);
        xfer(0, 1, 2'b11, 13'h020, 12, RD_HALF);
        chk("R9 oe low after aborted read", oe, 1'b0);
        xfer(0, 1, 2'b00, 13'h050, 8, RD_HALF);
        chk("R9 partial byte discarded", rx[0], 8'h00);
        xfer(0, 1, 2'b00, 13'h021, 8, RD_HALF);
        chk("R9 fresh header after abort", rx[0], 8'hB2);
    endtask

    task automatic t_order();
        tx[0] = 8'hFF; tx[1] = 8'h71;
        xfer(0, 0, 2'b11, 13'h000, 16, WR_HALF);
        xfer(1, 1, 2'b01, 13'h000, 16, RD_HALF);
        chk("R8 reserved bits read zero", rx[0], 8'h40);
        chk("R7 order held until frame end", rx[1], 8'h71);
        tx[0] = 8'h3C;
        xfer(1, 0, 2'b00, 13'h060, 8, WR_HALF);
        xfer(1, 1, 2'b00, 13'h060, 8, RD_HALF);
        chk("R6 lsb-first round trip", rx[0], 8'h3C);
        xfer(1, 1, 2'b00, 13'h022, 8, RD_HALF);
        chk("R6 lsb-first reads older data", rx[0], 8'hC3);
        tx[0] = 8'h00;
        xfer(1, 0, 2'b00, 13'h000, 8, WR_HALF);
        xfer(0, 1, 2'b00, 13'h060, 8, RD_HALF);
        chk("R7 msb-first restored next frame", rx[0], 8'h3C);
    endtask

    task automatic t_slow();
        tx[0] = 8'h96;
        xfer(0, 0, 2'b00, 13'h070, 8, 150);
        xfer(0, 1, 2'b00, 13'h070, 8, 150);
        chk("R10 slow clock round trip", rx[0], 8'h96);
    endtask

    initial begin
        foreach (tx[k]) tx[k] = 8'h00;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_msb_rw();
        t_len_limit();
        t_stream();
        t_high();
        t_abort();
        t_order();
        t_slow();
        summary();
    end
endmodule